// File: doc/BRIEF.md
# Processor Sleep and Wakeup Controller

This block decides when a small processor core goes to sleep and when it comes back. The core signals one of three requests: a wait-for-interrupt, a wait-for-event or a send-event pulse. It also signals when a handler returns to thread mode. The block compares the pending, enabled and prioritised interrupt vectors against the current execution priority. From that it drives a sleep flag, a one-cycle wake pulse and a separate permission to take an exception.

Waking and exception entry are kept apart. With the global interrupt mask set, a qualifying interrupt still wakes the core, so restore code can run first. The handler is permitted only once the mask drops. A one-bit event register serves the wait-for-event path. It is set by a local send-event pulse, by an event arriving from another core or, when pend-to-event mode is on, by any newly pending interrupt. Pend-to-event mode counts an interrupt even when it is disabled or its priority is too low.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset `sleeping`, `wakePulse` and `takeExc` are 0 and the event register is clear.
- R2: A `wfiReq` pulse seen while awake sets `sleeping` at the next clock edge. The flag stays set while no interrupt qualifies.
- R3: Interrupt i qualifies only when its pending and enable bits are both 1 and its priority field `irqPrio[i*PRIO_W +: PRIO_W]`, zero-extended, is strictly less than `curPrio`. A lower value means a higher priority. An equal value or a disabled line does not qualify.
- R4: A `threadReturn` pulse with `sleepOnExit`=1 enters sleep with no wait request. With `sleepOnExit`=0 the core stays awake.
- R5: `takeExc` is 1 exactly when the core is awake, some interrupt qualifies and `primask` is 0. With `primask`=1, a qualifying interrupt still wakes the core, but `takeExc` stays 0 until `primask` returns to 0.
- R6: When a wake condition holds in a sleeping cycle, `sleeping` falls at the next edge. `wakePulse` is 1 for exactly that one following cycle.
- R7: The event register is set by `sevPulse` or `extEvtIn`. It is also set by a 0-to-1 change of any `irqPending` bit while `sevOnPend`=1, whatever that line's enable and priority. A set in the same cycle as a clear wins. The register holds until it is cleared.
- R8: A `wfeReq` seen while the event register is set clears the register and does not sleep. A `wfeReq` seen while it is clear enters sleep at the next edge.
- R9: A wait-for-event sleep ends on a qualifying interrupt, one edge after the interrupt appears, or on a set event register, two edges after the setting pulse. The wake consumes the event.
- R10: A pending bit that stays high does not set the event again. A new pending with `sevOnPend`=0 sets nothing. A set event never ends a wait-for-interrupt sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wfiReq | input | 1 | Wait-for-interrupt request pulse |
| wfeReq | input | 1 | Wait-for-event request pulse |
| sevPulse | input | 1 | Send-event pulse from this core |
| extEvtIn | input | 1 | Event pulse from another core |
| threadReturn | input | 1 | Handler return to thread mode |
| sleepOnExit | input | 1 | Sleep when a handler returns to thread mode |
| sevOnPend | input | 1 | Newly pending interrupts set the event |
| primask | input | 1 | Global interrupt mask |
| irqPending | input | NUM_IRQ | Per-line pending bits |
| irqEnable | input | NUM_IRQ | Per-line enable bits |
| irqPrio | input | NUM_IRQ*PRIO_W | Per-line priority, line i at bits i*PRIO_W |
| curPrio | input | PRIO_W+1 | Current execution priority |
| sleeping | output | 1 | Core is asleep |
| wakePulse | output | 1 | One-cycle wake indication |
| takeExc | output | 1 | Exception entry permitted |

## Verification
Sleep entry after a request appears one edge later. An interrupt-driven wake also lowers `sleeping` and raises `wakePulse` one edge after the interrupt is driven. An event-driven wake needs two edges, because the event register sits in between. `takeExc` follows its inputs within the same cycle. Every stimulus is applied at a falling edge, and each result is read at the falling edge that follows exactly that many rising edges. The checks in between confirm that nothing has moved early.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_WFI   = 2'd1,
    ST_WFE   = 2'd2
  } slpState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic evtClr;   // consume the event register
    logic wfeWait;  // currently in a wait-for-event sleep
  } dpStrobe_t;

endpackage

// File: rtl/sleep_wake_dp.sv
module sleep_wake_dp
  import sleep_wake_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic                      sevPulse,
  input  logic                      extEvtIn,
  input  logic                      sevOnPend,
  input  logic [NUM_IRQ-1:0]        irqPending,
  input  logic [NUM_IRQ-1:0]        irqEnable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W:0]           curPrio,
  output logic                      anyQual,
  output logic                      evtQ
);

  localparam int CMP_W = PRIO_W + 1;

  logic [NUM_IRQ-1:0] qualVec;
  logic [NUM_IRQ-1:0] pendPrev;
  logic [NUM_IRQ-1:0] pendRise;
  logic               evtSet;

  // per-line qualification: pending, enabled, strictly higher priority
  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_qual
    logic [CMP_W-1:0] linePrio;
    assign linePrio    = {1'b0, irqPrio[gi*PRIO_W +: PRIO_W]};
    assign qualVec[gi] = irqPending[gi] & irqEnable[gi] & (linePrio < curPrio);
  end

  assign anyQual  = |qualVec;
  assign pendRise = irqPending & ~pendPrev;
  assign evtSet   = sevPulse | extEvtIn | (sevOnPend & (|pendRise));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPrev <= '0;
      evtQ     <= 1'b0;
    end else begin
      pendPrev <= irqPending;
      evtQ     <= (evtQ & ~strobe.evtClr) | evtSet;
    end
  end

  a_r7_event_set: assert property (@(posedge clk) disable iff (!rstN)
    (sevPulse || extEvtIn) |=> evtQ);

  a_r10_evt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (evtQ && !strobe.evtClr) |=> evtQ);

endmodule

// File: rtl/sleep_wake_fsm.sv
module sleep_wake_fsm
  import sleep_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wfiReq,
  input  logic      wfeReq,
  input  logic      threadReturn,
  input  logic      sleepOnExit,
  input  logic      primask,
  input  logic      anyQual,
  input  logic      evtQ,
  output dpStrobe_t strobe,
  output logic      sleeping,
  output logic      wakePulse,
  output logic      takeExc
);

  slpState_e state, stateNext;
  logic      wakeCond;
  logic      wakeNext;

  always_comb begin
    stateNext     = state;
    wakeNext      = 1'b0;
    wakeCond      = 1'b0;
    strobe.evtClr = 1'b0;
    strobe.wfeWait = (state == ST_WFE);
    unique case (state)
      ST_AWAKE: begin
        if (wfiReq) begin
          stateNext = ST_WFI;
        end else if (wfeReq) begin
          strobe.evtClr = 1'b1;
          if (!evtQ) stateNext = ST_WFE;
        end else if (threadReturn && sleepOnExit) begin
          stateNext = ST_WFI;
        end
      end
      ST_WFI: begin
        wakeCond = anyQual;
        if (wakeCond) begin
          stateNext = ST_AWAKE;
          wakeNext  = 1'b1;
        end
      end
      ST_WFE: begin
        wakeCond = anyQual | evtQ;
        if (wakeCond) begin
          stateNext     = ST_AWAKE;
          wakeNext      = 1'b1;
          strobe.evtClr = 1'b1;
        end
      end
      default: stateNext = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_AWAKE;
      wakePulse <= 1'b0;
    end else begin
      state     <= stateNext;
      wakePulse <= wakeNext;
    end
  end

  assign sleeping = (state != ST_AWAKE);
  assign takeExc  = (state == ST_AWAKE) & anyQual & ~primask;

  a_r6_wake_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  a_r6_wake_ends_sleep: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!sleeping && $past(sleeping)));

  a_r5_take_when_awake: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> (!sleeping && !primask && anyQual));

  a_r2_wfi_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WFI && !anyQual) |=> sleeping);

  a_r8_wfe_with_event: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && wfeReq && !wfiReq && evtQ) |=> !sleeping);

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wfiReq,
  input  logic                      wfeReq,
  input  logic                      sevPulse,
  input  logic                      extEvtIn,
  input  logic                      threadReturn,
  input  logic                      sleepOnExit,
  input  logic                      sevOnPend,
  input  logic                      primask,
  input  logic [NUM_IRQ-1:0]        irqPending,
  input  logic [NUM_IRQ-1:0]        irqEnable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W:0]           curPrio,
  output logic                      sleeping,
  output logic                      wakePulse,
  output logic                      takeExc
);

  dpStrobe_t strobe;
  logic      anyQual;
  logic      evtQ;

  sleep_wake_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sevPulse   (sevPulse),
    .extEvtIn   (extEvtIn),
    .sevOnPend  (sevOnPend),
    .irqPending (irqPending),
    .irqEnable  (irqEnable),
    .irqPrio    (irqPrio),
    .curPrio    (curPrio),
    .anyQual    (anyQual),
    .evtQ       (evtQ)
  );

  sleep_wake_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .wfiReq       (wfiReq),
    .wfeReq       (wfeReq),
    .threadReturn (threadReturn),
    .sleepOnExit  (sleepOnExit),
    .primask      (primask),
    .anyQual      (anyQual),
    .evtQ         (evtQ),
    .strobe       (strobe),
    .sleeping     (sleeping),
    .wakePulse    (wakePulse),
    .takeExc      (takeExc)
  );

endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;

  localparam int NUM_IRQ = 8;
  localparam int PRIO_W  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wfiReq = 0, wfeReq = 0, sevPulse = 0, extEvtIn = 0, threadReturn = 0;
  logic sleepOnExit = 0, sevOnPend = 0, primask = 0;
  logic [NUM_IRQ-1:0]        irqPending = '0;
  logic [NUM_IRQ-1:0]        irqEnable  = '0;
  logic [NUM_IRQ*PRIO_W-1:0] irqPrio    = '0;
  logic [PRIO_W:0]           curPrio    = 3'd4;
  logic sleeping, wakePulse, takeExc;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  sleep_wake_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_sleep_wake_ctrl (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .wfeReq(wfeReq),
    .sevPulse(sevPulse), .extEvtIn(extEvtIn), .threadReturn(threadReturn),
    .sleepOnExit(sleepOnExit), .sevOnPend(sevOnPend), .primask(primask),
    .irqPending(irqPending), .irqEnable(irqEnable), .irqPrio(irqPrio),
    .curPrio(curPrio), .sleeping(sleeping), .wakePulse(wakePulse),
    .takeExc(takeExc)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic outs(string req, logic s, logic w, logic t);
    check(req, "sleeping", sleeping, s);
    check(req, "wakePulse", wakePulse, w);
    check(req, "takeExc", takeExc, t);
  endtask

  task automatic pulseWfi();
    wfiReq = 1; tick(); wfiReq = 0;
  endtask

  task automatic pulseWfe();
    wfeReq = 1; tick(); wfeReq = 0;
  endtask

  task automatic setPrio(int line, int val);
    irqPrio[line*PRIO_W +: PRIO_W] = PRIO_W'(val);
  endtask

  task automatic clearIrqs();
    irqPending = '0; irqEnable = '0; tick();
  endtask

  // R1
  task automatic testReset();
    outs("R1", 1'b0, 1'b0, 1'b0);
    // event clear: WFE must sleep
    pulseWfe();
    check("R1", "wfe sleeps with clear event", sleeping, 1'b1);
    extEvtIn = 1; tick(); extEvtIn = 0;
    tick();
    outs("R1", 1'b0, 1'b1, 1'b0);
    tick();
  endtask

  // R2 R3 R6
  task automatic testWfi();
    pulseWfi();
    outs("R2", 1'b1, 1'b0, 1'b0);
    irqPending[0] = 1; setPrio(0, 0); tick(2);
    check("R3", "disabled line keeps sleep", sleeping, 1'b1);
    curPrio = 3'd2; setPrio(1, 2); irqEnable[1] = 1; irqPending[1] = 1; tick(2);
    check("R3", "equal priority keeps sleep", sleeping, 1'b1);
    setPrio(1, 1); tick();
    outs("R6", 1'b0, 1'b1, 1'b1);
    tick();
    check("R6", "pulse one cycle", wakePulse, 1'b0);
    check("R5", "take while awake", takeExc, 1'b1);
    clearIrqs();
    curPrio = 3'd4;
  endtask

  // R5
  task automatic testPrimask();
    primask = 1;
    pulseWfi();
    check("R2", "wfi entry", sleeping, 1'b1);
    setPrio(2, 3); irqEnable[2] = 1; irqPending[2] = 1; tick();
    outs("R5", 1'b0, 1'b1, 1'b0);
    tick();
    check("R5", "take held by mask", takeExc, 1'b0);
    primask = 0; #1;
    check("R5", "take after mask drop", takeExc, 1'b1);
    clearIrqs();
  endtask

  // R4
  task automatic testSleepOnExit();
    sleepOnExit = 0; threadReturn = 1; tick(); threadReturn = 0;
    check("R4", "no sleep with control off", sleeping, 1'b0);
    sleepOnExit = 1; threadReturn = 1; tick(); threadReturn = 0;
    check("R4", "sleep on exit", sleeping, 1'b1);
    tick(2);
    check("R4", "still asleep", sleeping, 1'b1);
    irqEnable[3] = 1; setPrio(3, 0); irqPending[3] = 1; tick();
    outs("R4", 1'b0, 1'b1, 1'b1);
    sleepOnExit = 0;
    clearIrqs();
  endtask

  // R7 R8 R9
  task automatic testWfe();
    sevPulse = 1; tick(); sevPulse = 0;
    pulseWfe();
    check("R8", "wfe returns at once", sleeping, 1'b0);
    pulseWfe();
    check("R8", "second wfe sleeps", sleeping, 1'b1);
    extEvtIn = 1; tick(); extEvtIn = 0;
    check("R9", "event not yet seen", sleeping, 1'b1);
    tick();
    outs("R9", 1'b0, 1'b1, 1'b0);
    tick();
    pulseWfe();
    check("R9", "event consumed by wake", sleeping, 1'b1);
    irqEnable[4] = 1; setPrio(4, 1); irqPending[4] = 1;
    // sevOnPend is 0, so only qualification wakes
    tick();
    outs("R9", 1'b0, 1'b1, 1'b1);
    clearIrqs();
    // R7: sev and wfe in same cycle, set wins
    sevPulse = 1; wfeReq = 1; tick(); sevPulse = 0; wfeReq = 0;
    check("R7", "wfe with simultaneous sev", sleeping, 1'b1);
    tick();
    check("R7", "set wins over clear", sleeping, 1'b0);
    tick();
  endtask

  // R7 R10
  task automatic testSevOnPend();
    sevOnPend = 1;
    pulseWfe();
    check("R7", "wfe sleep", sleeping, 1'b1);
    irqPending[5] = 1; tick();
    check("R7", "disabled pend not yet", sleeping, 1'b1);
    tick();
    outs("R7", 1'b0, 1'b1, 1'b0);
    tick();
    pulseWfe();
    tick(3);
    check("R10", "held pending no new event", sleeping, 1'b1);
    sevOnPend = 0; irqPending[6] = 1; tick(3);
    check("R10", "new pend with control off", sleeping, 1'b1);
    extEvtIn = 1; tick(); extEvtIn = 0; tick();
    check("R9", "ext event wake", sleeping, 1'b0);
    irqPending = '0; tick();
    sevOnPend = 1;
    pulseWfi();
    irqPending[7] = 1; tick(3);
    check("R10", "event does not end wfi", sleeping, 1'b1);
    irqEnable[7] = 1; setPrio(7, 0); tick();
    outs("R10", 1'b0, 1'b1, 1'b1);
    sevOnPend = 0;
    clearIrqs();
  endtask

  initial begin
    tick(2);
    rstN = 1;
    tick();
    testReset();
    testWfi();
    testPrimask();
    testSleepOnExit();
    testWfe();
    testSevOnPend();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule